// File: doc/BRIEF.md
# SPI Slave Command Responder

This block is the slave end of a command link in which a host acts as SPI master (mode 0, MSB first) and a controller answers. The host clocks in a command of one to four bytes while chip-select is low. When chip-select rises, every command byte is already held in a four-byte receive store, so the block hands the command to the controller logic in a single cycle. The controller logic answers in that same cycle. The block fetches the response length for the command code from a parameter table, loads up to three response bytes into a transmit store, and then drives its acknowledge output low for one cycle. That rising edge tells the host the response is ready to read.

The host reads a pending response in its next chip-select frame. During that frame the block shifts the stored bytes out on MISO and does not treat the incoming bytes as a command. A zero-length response leaves nothing pending, so the host may send its next command straight after the acknowledge edge.

Unsolicited data from the controller side is queued as 3-byte items. The request output is high while any item waits. The host fetches an item by sending a receive-ready command, whose response is the oldest queued item. Request drops while that response is loaded and acknowledged, and it comes back only if more items remain.

Top module: `scmd_responder`

## Requirements
- R1: Command bytes are sampled on SCLK rising edges while chip-select is low, MSB first. Up to 4 bytes are kept, and bytes past the fourth are ignored. Argument bytes that were not sent read as zero, and the byte count saturates at 4.
- R2: When chip-select rises after at least one complete byte, `cmd_valid` pulses for one cycle. The first byte appears on `cmd_code`, the second on `cmd_args[7:0]`, the third on `cmd_args[15:8]` and the fourth on `cmd_args[23:16]`, with the byte count on `cmd_nbytes`. A chip-select frame with no complete byte produces no command and no acknowledge.
- R3: The response length comes from a table. By default code 0x10 gives 0 bytes, 0x20 gives 1, 0x30 gives 2 and 0x40 gives 3. Any code not in the table gives 0 bytes. After a 0-byte response nothing is pending, and the next frame is taken as a command.
- R4: Response byte k is taken from `rsp_data[8k+7:8k]` in the `cmd_valid` cycle. In the host's next frame, byte 0 is shifted out first, MSB first. Bytes at or beyond the response length read as zero. MISO is low after reset and while a command is clocked in with no response pending.
- R5: `rsp_ack` is high when idle. It goes low for exactly one cycle, the cycle after `cmd_valid`, once the response is loaded.
- R6: While a response is pending, the next chip-select frame is a readout. It yields no `cmd_valid` and no acknowledge, and when it ends no response is pending any more.
- R7: `unsol_req` is high whenever the unsolicited queue holds an item, and low otherwise, except as R8 states. An item enters the queue when `evt_push` is high, taking `evt_data`, whose bits [7:0] are sent first.
- R8: Command code 0xA5 (receive-ready) has a 3-byte response, which carries the oldest queued item and removes it from the queue. `unsol_req` stays low from the load through the acknowledge cycle and afterwards shows whether items remain. With an empty queue the response is three zero bytes.
- R9: The queue holds 2 items. A push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host (mode 0) |
| spi_cs_n | input | 1 | SPI chip-select from the host, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rsp_ack | output | 1 | Response-ready flag, pulses low for one cycle |
| unsol_req | output | 1 | Unsolicited data waiting |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | First command byte |
| cmd_args | output | 24 | Command bytes 2 to 4, byte 2 in the low bits |
| cmd_nbytes | output | 3 | Number of command bytes received (1 to 4) |
| rsp_data | input | 24 | Response bytes for the current command, byte 0 in the low bits |
| evt_push | input | 1 | Enqueue one unsolicited item |
| evt_data | input | 24 | Unsolicited item, byte 0 in the low bits |

## Verification
Commands are driven with one, two, four and five bytes, and with a chip-select frame that carries no clocks at all. These patterns separate correct byte counting and the discarding of extra bytes from off-by-one storage. The codes used have response lengths of zero, one, two and three, plus one code missing from the table. These show whether zero padding and the skipping of the readout frame follow the length table. One readout frame carries nonzero MOSI data, which shows that a pending response turns the next frame into a readout rather than a command. The unsolicited queue is filled past its depth and then drained with receive-ready commands until it is empty. This separates the ordering, the dropping of excess pushes, the masking of the request during the acknowledge, and the zero response given when nothing is queued.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ACKL = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/scmd_pin_sync.sv
module scmd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_low,
  output logic mosi_s
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES:0]   cs_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk};
      cs_q   <= {cs_q[STAGES-1:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign cs_rise   = cs_q[STAGES-1] & ~cs_q[STAGES];
  assign cs_fall   = ~cs_q[STAGES-1] & cs_q[STAGES];
  assign cs_low    = ~cs_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/scmd_rx_buf.sv
module scmd_rx_buf #(
  parameter int NBYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         bit_en,
  input  logic                         bit_in,
  output logic [NBYTES*8-1:0]          bytes_o,
  output logic [$clog2(NBYTES+1)-1:0]  count_o
);
  localparam int CNT_W = $clog2(NBYTES+1);

  logic [6:0]          part_q;
  logic [2:0]          bit_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [NBYTES*8-1:0] bytes_q;
  logic [7:0]          full_byte;
  logic                store_en;

  assign full_byte = {part_q, bit_in};
  assign store_en  = bit_en && (bit_q == 3'd7) && (cnt_q != CNT_W'(NBYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q  <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else if (start) begin
      bit_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else if (bit_en) begin
      part_q <= full_byte[6:0];
      bit_q  <= bit_q + 3'd1;
      if (store_en) begin
        cnt_q <= cnt_q + 1'b1;
        for (int i = 0; i < NBYTES; i++) begin
          if (cnt_q == CNT_W'(i)) bytes_q[i*8 +: 8] <= full_byte;
        end
      end
    end
  end

  assign bytes_o = bytes_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/scmd_tx_buf.sv
module scmd_tx_buf #(
  parameter int NBYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NBYTES*8-1:0]         load_data,
  input  logic [$clog2(NBYTES+1)-1:0] load_len,
  input  logic                        start,
  input  logic                        shift,
  input  logic                        enable,
  output logic                        miso
);
  localparam int LEN_W = $clog2(NBYTES+1);

  logic [NBYTES*8-1:0] buf_q;
  logic [7:0]          sh_q;
  logic [2:0]          bit_q;
  logic [LEN_W-1:0]    idx_q;

  function automatic logic [7:0] pick(input logic [NBYTES*8-1:0] b, input logic [LEN_W-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx == LEN_W'(i)) r = b[i*8 +: 8];
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (load) begin
      for (int i = 0; i < NBYTES; i++) begin
        buf_q[i*8 +: 8] <= (LEN_W'(i) < load_len) ? load_data[i*8 +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      sh_q  <= enable ? pick(buf_q, '0) : 8'h00;
      bit_q <= '0;
      idx_q <= LEN_W'(1);
    end else if (shift) begin
      if (bit_q == 3'd7) begin
        sh_q  <= enable ? pick(buf_q, idx_q) : 8'h00;
        bit_q <= '0;
        if (idx_q != LEN_W'(NBYTES)) idx_q <= idx_q + 1'b1;
      end else begin
        sh_q  <= {sh_q[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
      end
    end
  end

  assign miso = sh_q[7];
endmodule

// File: rtl/scmd_evt_fifo.sv
module scmd_evt_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din;
        wr_q        <= bump(wr_q);
      end
      if (do_pop) rd_q <= bump(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout    = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/scmd_responder.sv
module scmd_responder #(
  parameter int   CMD_MAX     = 4,
  parameter int   RSP_MAX     = 3,
  parameter int   EVT_DEPTH   = 2,
  parameter int   SYNC_STAGES = 2,
  parameter int   NUM_CODES   = 4,
  parameter logic [NUM_CODES*8-1:0] CODE_TABLE = {8'h40, 8'h30, 8'h20, 8'h10},
  parameter logic [NUM_CODES*$clog2(RSP_MAX+1)-1:0] LEN_TABLE = {2'd3, 2'd2, 2'd1, 2'd0},
  parameter logic [7:0] RR_CODE = 8'hA5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            spi_sclk,
  input  logic                            spi_cs_n,
  input  logic                            spi_mosi,
  output logic                            spi_miso,
  output logic                            rsp_ack,
  output logic                            unsol_req,
  output logic                            cmd_valid,
  output logic [7:0]                      cmd_code,
  output logic [(CMD_MAX-1)*8-1:0]        cmd_args,
  output logic [$clog2(CMD_MAX+1)-1:0]    cmd_nbytes,
  input  logic [RSP_MAX*8-1:0]            rsp_data,
  input  logic                            evt_push,
  input  logic [RSP_MAX*8-1:0]            evt_data
);
  import scmd_pkg::*;

  localparam int CNT_W = $clog2(CMD_MAX+1);
  localparam int LEN_W = $clog2(RSP_MAX+1);
  localparam int RSP_W = RSP_MAX*BYTE_W;

  logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_low, mosi_s;
  logic [CMD_MAX*8-1:0] rx_bytes;
  logic [CNT_W-1:0]     rx_cnt;
  logic [RSP_W-1:0]     evt_head, load_data;
  logic                 evt_empty, is_rr, tx_load;
  logic [LEN_W-1:0]     rsp_len;

  ctl_state_t state_q, state_d;
  logic       pend_q, pend_d;
  logic       hold_q, hold_d;

  scmd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .cs_low(cs_low), .mosi_s(mosi_s)
  );

  scmd_rx_buf #(.NBYTES(CMD_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(cs_fall), .bit_en(sclk_rise & cs_low),
    .bit_in(mosi_s), .bytes_o(rx_bytes), .count_o(rx_cnt)
  );

  scmd_tx_buf #(.NBYTES(RSP_MAX)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(load_data),
    .load_len(rsp_len), .start(cs_fall), .shift(sclk_fall & cs_low),
    .enable(pend_q), .miso(spi_miso)
  );

  scmd_evt_fifo #(.DEPTH(EVT_DEPTH), .W(RSP_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .push(evt_push), .din(evt_data),
    .pop(tx_load & is_rr), .dout(evt_head), .empty_o(evt_empty)
  );

  assign is_rr   = (rx_bytes[7:0] == RR_CODE);
  assign tx_load = (state_q == ST_LOAD);

  always_comb begin
    rsp_len = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (rx_bytes[7:0] == CODE_TABLE[i*8 +: 8]) rsp_len = LEN_TABLE[i*LEN_W +: LEN_W];
    end
    if (is_rr) rsp_len = LEN_W'(RSP_MAX);
  end

  always_comb begin
    if (!is_rr)         load_data = rsp_data;
    else if (evt_empty) load_data = '0;
    else                load_data = evt_head;
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    hold_d  = hold_q;
    case (state_q)
      ST_IDLE: begin
        if (cs_rise) begin
          if (pend_q)             pend_d  = 1'b0;
          else if (rx_cnt != '0)  state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        pend_d  = (rsp_len != '0);
        hold_d  = hold_q | is_rr;
        state_d = ST_ACKL;
      end
      ST_ACKL: begin
        hold_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  assign rsp_ack    = (state_q != ST_ACKL);
  assign unsol_req  = !evt_empty && !hold_q;
  assign cmd_valid  = tx_load;
  assign cmd_code   = rx_bytes[7:0];
  assign cmd_args   = rx_bytes[CMD_MAX*8-1:8];
  assign cmd_nbytes = rx_cnt;
endmodule

// File: rtl/scmd_responder_chk.sv
module scmd_responder_chk #(
  parameter logic [7:0] RR_CODE = 8'hA5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rsp_ack,
  input logic       unsol_req,
  input logic       cmd_valid,
  input logic [7:0] cmd_code
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ack |=> rsp_ack); // R5
  AST_CMD_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !rsp_ack); // R5
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2
  AST_ACK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_ack) |-> $past(cmd_valid)); // R6
  AST_RR_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == RR_CODE) |=> !unsol_req); // R8
endmodule

bind scmd_responder scmd_responder_chk #(.RR_CODE(RR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_ack(rsp_ack), .unsol_req(unsol_req),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/scmd_responder_tb_top.sv
`timescale 1ns/1ps
module scmd_responder_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        rsp_ack, unsol_req, cmd_valid, evt_push;
  logic [7:0]  cmd_code;
  logic [23:0] cmd_args, rsp_data, evt_data;
  logic [2:0]  cmd_nbytes;

  assign rsp_data = {cmd_code ^ 8'h33, cmd_code ^ 8'h22, cmd_code ^ 8'h11};

  scmd_responder dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rsp_ack(rsp_ack),
    .unsol_req(unsol_req), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_args(cmd_args), .cmd_nbytes(cmd_nbytes), .rsp_data(rsp_data),
    .evt_push(evt_push), .evt_data(evt_data)
  );

  typedef struct {
    logic [7:0]  code;
    logic [2:0]  n;
    logic [23:0] args;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cmd_seen = 0;
  logic req_lo, req_hi;

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected commands as the design presents them
  exp_t got_e;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmd_valid === 1'b1) begin
      cmd_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected command", {32'h0, cmd_code}, 40'h0);
      end else begin
        got_e = exp_q.pop_front();
        check(cmd_code == got_e.code && cmd_nbytes == got_e.n && cmd_args == got_e.args,
              "R2 command fields", {cmd_args, 5'b0, cmd_nbytes, cmd_code},
              {got_e.args, 5'b0, got_e.n, got_e.code});
      end
    end
  end

  task automatic spi_xfer(input int n, input logic [39:0] txb, output logic [39:0] rxb);
    rxb = '0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = txb[b*8+i];
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b1;
        rxb[b*8+i] = spi_miso;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
  endtask

  task automatic wait_ack(input string tag, output logic rlo, output logic rhi);
    int k = 0;
    while (rsp_ack === 1'b1 && k < 40) begin
      @(negedge clk);
      k++;
    end
    check(rsp_ack === 1'b0, {tag, " R5 ack low"}, {39'h0, rsp_ack}, 40'h0);
    rlo = unsol_req;
    @(negedge clk);
    check(rsp_ack === 1'b1, {tag, " R5 ack high after one cycle"}, {39'h0, rsp_ack}, 40'h1);
    rhi = unsol_req;
    repeat (4) @(negedge clk);
  endtask

  task automatic no_ack(input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rsp_ack !== 1'b1) seen = 1'b1;
    end
    check(!seen, tag, {39'h0, seen}, 40'h0);
  endtask

  task automatic send_cmd(input int n, input logic [39:0] txb, input logic [7:0] code,
                          input logic [2:0] nb, input logic [23:0] args, input string tag,
                          output logic rlo, output logic rhi);
    logic [39:0] rx;
    exp_t e;
    e.code = code; e.n = nb; e.args = args;
    exp_q.push_back(e);
    spi_xfer(n, txb, rx);
    check(rx == 40'h0, "R4 miso low during command", rx, 40'h0);
    wait_ack(tag, rlo, rhi);
  endtask

  task automatic readout(input logic [23:0] exp, input string tag);
    logic [39:0] rx;
    spi_xfer(3, 40'h0, rx);
    check(rx[23:0] == exp, tag, rx, {16'h0, exp});
    repeat (10) @(negedge clk);
  endtask

  task automatic push_evt(input logic [23:0] d);
    evt_push = 1'b1;
    evt_data = d;
    @(negedge clk);
    evt_push = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [39:0] rx;
    int seen0;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    evt_push = 1'b0; evt_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(rsp_ack === 1'b1, "R5 reset ack high", {39'h0, rsp_ack}, 40'h1);
    check(unsol_req === 1'b0, "R7 reset req low", {39'h0, unsol_req}, 40'h0);
    check(spi_miso === 1'b0, "R4 reset miso low", {39'h0, spi_miso}, 40'h0);

    // one-byte command, one-byte response
    send_cmd(1, 40'h20, 8'h20, 3'd1, 24'h0, "R2 one byte", req_lo, req_hi);
    readout(24'h000031, "R4 one-byte response padded with zeros");

    // four-byte command, three-byte response
    send_cmd(4, 40'h0003020140, 8'h40, 3'd4, 24'h030201, "R1 four bytes", req_lo, req_hi);
    readout(24'h736251, "R3 three-byte response order");

    // five bytes: fifth ignored (R1), then a pending response makes the next frame a readout (R6)
    send_cmd(5, 40'hDDCCBBAA30, 8'h30, 3'd4, 24'hCCBBAA, "R1 extra byte", req_lo, req_hi);
    seen0 = cmd_seen;
    spi_xfer(3, 40'h000020, rx);
    check(rx[23:0] == 24'h001221, "R6 readout with data on mosi", rx, 40'h001221);
    no_ack("R6 no ack for readout");
    check(cmd_seen == seen0, "R6 readout is not a command", cmd_seen, seen0);

    // unknown code: zero length, next frame is a command again
    send_cmd(1, 40'h77, 8'h77, 3'd1, 24'h0, "R3 unknown code", req_lo, req_hi);
    send_cmd(1, 40'h10, 8'h10, 3'd1, 24'h0, "R3 after zero length", req_lo, req_hi);
    send_cmd(2, 40'h5A10, 8'h10, 3'd2, 24'h00005A, "R1 two bytes", req_lo, req_hi);

    // chip-select frame without clocks
    seen0 = cmd_seen;
    spi_cs_n = 1'b0;
    repeat (10) @(negedge clk);
    spi_cs_n = 1'b1;
    no_ack("R2 empty frame gives no ack");
    check(cmd_seen == seen0, "R2 empty frame gives no command", cmd_seen, seen0);

    // unsolicited data
    push_evt(24'h0C0B0A);
    push_evt(24'h1C1B1A);
    check(unsol_req === 1'b1, "R7 req with queued data", {39'h0, unsol_req}, 40'h1);
    send_cmd(1, 40'hA5, 8'hA5, 3'd1, 24'h0, "R8 first fetch", req_lo, req_hi);
    check(req_lo === 1'b0, "R8 req low during ack", {39'h0, req_lo}, 40'h0);
    check(req_hi === 1'b1, "R7 req back with data left", {39'h0, req_hi}, 40'h1);
    readout(24'h0C0B0A, "R8 oldest item first");
    send_cmd(1, 40'hA5, 8'hA5, 3'd1, 24'h0, "R8 second fetch", req_lo, req_hi);
    check(req_hi === 1'b0, "R7 req low once drained", {39'h0, req_hi}, 40'h0);
    readout(24'h1C1B1A, "R8 second item");

    push_evt(24'h2C2B2A);
    push_evt(24'h3C3B3A);
    push_evt(24'h4C4B4A);
    send_cmd(1, 40'hA5, 8'hA5, 3'd1, 24'h0, "R9 fetch after overflow", req_lo, req_hi);
    check(req_hi === 1'b1, "R9 second stored item pending", {39'h0, req_hi}, 40'h1);
    readout(24'h2C2B2A, "R9 first stored item");
    send_cmd(1, 40'hA5, 8'hA5, 3'd1, 24'h0, "R9 fetch", req_lo, req_hi);
    check(req_hi === 1'b0, "R9 push while full dropped", {39'h0, req_hi}, 40'h0);
    readout(24'h3C3B3A, "R9 second stored item");
    send_cmd(1, 40'hA5, 8'hA5, 3'd1, 24'h0, "R8 fetch on empty", req_lo, req_hi);
    readout(24'h000000, "R8 empty queue gives zeros");

    check(exp_q.size() == 0, "R2 all expected commands seen", exp_q.size(), 40'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule